// File: doc/BRIEF.md
# Sleep and Interrupt Wake-up Sequencer

This block decides, for a small core whose instruction cycle spans four clock phases, whether a sleep instruction really powers the core down or acts as a no-operation. It also holds the core halted while an oscillator start-up delay runs and steers execution after wake-up. A wake source is any interrupt line whose enable and flag are both high. The global interrupt enable does not gate wake-up. It only selects what happens once the core resumes: either a jump to the interrupt vector after one extra instruction and one dummy cycle, or plain in-line continuation.

The instruction decoder raises one-cycle-wide strobes for sleep and watchdog-clear instructions. The block samples them in the last phase of the instruction cycle. The external watchdog counter takes the clear pulse, and the fetch unit takes the redirect request and its target address. The time-out and power-down status bits are kept here.

Top module: `sleep_wake_ctl`

## Requirements
- R1: After reset, core_halt, wdt_clr, ost_busy and redirect_vld are 0, and to_bit and pd_bit are 1.
- R2: The wake request is the OR over all sources of (int_en AND int_flag). A flag whose enable is low does not wake the core. gie has no effect on wake-up.
- R3: Strobes are sampled only in the fourth phase of an instruction cycle. If sleep_stb is sampled while a wake request is present, the instruction is a no-operation: no wdt_clr pulse, to_bit and pd_bit unchanged, and core_halt stays 0.
- R4: If sleep_stb is sampled with no wake request, the block gives one wdt_clr pulse one clock long, sets to_bit to 1, clears pd_bit to 0, and raises core_halt in the next clock. core_halt stays high until wake-up completes.
- R5: In the crystal modes (osc_mode 2'b00, 2'b01, 2'b10), ost_busy rises the clock after a wake request is seen while asleep and stays high for exactly OST_LEN (default 1024) clocks. core_halt falls together with ost_busy.
- R6: In the RC mode (osc_mode 2'b11), core_halt falls the clock after a wake request is seen while asleep, and ost_busy never rises.
- R7: If gie is 1 at release, redirect_vld pulses high for one clock with redirect_addr equal to VEC_ADDR (default 13'h004). The pulse comes seven clocks after the first clock with core_halt low: one instruction cycle for the next instruction, then one dummy cycle.
- R8: If gie is 0 at release, no redirect is issued.
- R9: A clrwdt_stb sampled while running gives one wdt_clr pulse one clock long and sets both to_bit and pd_bit to 1.
- R10: A wdt_tmo pulse clears to_bit in the next clock.
- R11: While halted or in the start-up delay, sleep_stb and clrwdt_stb have no effect: no wdt_clr pulse and pd_bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_stb | input | 1 | Sleep instruction decoded |
| clrwdt_stb | input | 1 | Watchdog-clear instruction decoded |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| gie | input | 1 | Global interrupt enable |
| int_en | input | N_SRC | Per-source interrupt enables |
| int_flag | input | N_SRC | Per-source interrupt flags |
| osc_mode | input | 2 | 00/01/10 crystal types, 11 RC |
| core_halt | output | 1 | Core stopped |
| wdt_clr | output | 1 | Clear pulse to watchdog and its scalers |
| to_bit | output | 1 | Time-out status |
| pd_bit | output | 1 | Power-down status (0 after sleep) |
| ost_busy | output | 1 | Start-up delay running |
| redirect_vld | output | 1 | Fetch redirect request |
| redirect_addr | output | ADDR_W | Redirect target |

## Verification
The bench arms a wake source before a sleep instruction. A design that samples the wake request too late would then power down and emit a spurious watchdog clear, and the scoreboard would report that pulse as unexpected. It raises a flag whose enable is low, to catch a wake request built with OR instead of AND. It also measures the start-up delay to the exact clock, which exposes an off-by-one counter or a delay that wrongly runs in RC mode. The vector redirect is matched against the exact clock seven cycles after release, so a missing dummy cycle or a redirect issued with gie low shows up as a mismatch.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

    typedef enum logic [2:0] {
        PW_RUN,
        PW_SLEEP,
        PW_OST,
        PW_POSTWAKE,
        PW_DUMMY
    } pw_state_e;

    localparam logic [1:0] OSC_LP = 2'b00;
    localparam logic [1:0] OSC_XT = 2'b01;
    localparam logic [1:0] OSC_HS = 2'b10;
    localparam logic [1:0] OSC_RC = 2'b11;

    typedef struct packed {
        pw_state_e state;
        logic      to_bit;
        logic      pd_bit;
        logic      wdt_clr;
    } pw_regs_t;

    function automatic logic needs_ost(input logic [1:0] mode);
        case (mode)
            OSC_LP, OSC_XT, OSC_HS: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sw_qphase.sv
module sw_qphase #(
    parameter  int PHASES = 4,
    localparam int PW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    output logic [PW-1:0] phase,
    output logic          last
);
    logic [PW-1:0] ph_d, ph_q;

    // Phase counter parks at the first phase while the core is stopped.
    always_comb begin
        if (freeze)
            ph_d = '0;
        else if (ph_q == PW'(PHASES - 1))
            ph_d = '0;
        else
            ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;
    assign last  = (ph_q == PW'(PHASES - 1));
endmodule

// File: rtl/sw_wake_or.sv
module sw_wake_or #(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0] int_en,
    input  logic [N_SRC-1:0] int_flag,
    output logic             wake
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = int_en[i] & int_flag[i];
    end

    assign wake = |hit;
endmodule

// File: rtl/sw_ost_timer.sv
module sw_ost_timer #(
    parameter  int LEN = 1024,
    localparam int CW  = $clog2(LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == CW'(LEN - 1));
endmodule

// File: rtl/sleep_wake_ctl.sv
module sleep_wake_ctl
    import sleep_wake_pkg::*;
#(
    parameter int                N_SRC    = 8,
    parameter int                ADDR_W   = 13,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 13'h004,
    parameter int                OST_LEN  = 1024,
    parameter int                PHASES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_stb,
    input  logic              clrwdt_stb,
    input  logic              wdt_tmo,
    input  logic              gie,
    input  logic [N_SRC-1:0]  int_en,
    input  logic [N_SRC-1:0]  int_flag,
    input  logic [1:0]        osc_mode,
    output logic              core_halt,
    output logic              wdt_clr,
    output logic              to_bit,
    output logic              pd_bit,
    output logic              ost_busy,
    output logic              redirect_vld,
    output logic [ADDR_W-1:0] redirect_addr
);
    localparam int PW = $clog2(PHASES);

    pw_regs_t      r_d, r_q;
    logic [PW-1:0] phase;
    logic          q_last;
    logic          wake;
    logic          ost_done;
    logic          frozen;
    pw_state_e     release_st;

    assign frozen     = (r_q.state == PW_SLEEP) || (r_q.state == PW_OST);
    assign release_st = gie ? PW_POSTWAKE : PW_RUN;

    sw_qphase #(.PHASES(PHASES)) u_qphase (
        .clk    (clk),
        .rst_n  (rst_n),
        .freeze (frozen),
        .phase  (phase),
        .last   (q_last)
    );

    sw_wake_or #(.N_SRC(N_SRC)) u_wake (
        .int_en   (int_en),
        .int_flag (int_flag),
        .wake     (wake)
    );

    sw_ost_timer #(.LEN(OST_LEN)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (r_q.state == PW_SLEEP),
        .run   (r_q.state == PW_OST),
        .done  (ost_done)
    );

    always_comb begin
        r_d         = r_q;
        r_d.wdt_clr = 1'b0;
        if (wdt_tmo)
            r_d.to_bit = 1'b0;
        case (r_q.state)
            PW_RUN: begin
                if (q_last) begin
                    if (sleep_stb) begin
                        // A pending wake source turns the sleep into a no-op.
                        if (!wake) begin
                            r_d.state   = PW_SLEEP;
                            r_d.wdt_clr = 1'b1;
                            r_d.to_bit  = 1'b1;
                            r_d.pd_bit  = 1'b0;
                        end
                    end else if (clrwdt_stb) begin
                        r_d.wdt_clr = 1'b1;
                        r_d.to_bit  = 1'b1;
                        r_d.pd_bit  = 1'b1;
                    end
                end
            end
            PW_SLEEP: begin
                if (wake)
                    r_d.state = needs_ost(osc_mode) ? PW_OST : release_st;
            end
            PW_OST: begin
                if (ost_done)
                    r_d.state = release_st;
            end
            PW_POSTWAKE: begin
                if (q_last)
                    r_d.state = PW_DUMMY;
            end
            PW_DUMMY: begin
                if (q_last)
                    r_d.state = PW_RUN;
            end
            default: r_d.state = PW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= PW_RUN;
            r_q.to_bit  <= 1'b1;
            r_q.pd_bit  <= 1'b1;
            r_q.wdt_clr <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_halt     = frozen;
    assign wdt_clr       = r_q.wdt_clr;
    assign to_bit        = r_q.to_bit;
    assign pd_bit        = r_q.pd_bit;
    assign ost_busy      = (r_q.state == PW_OST);
    assign redirect_vld  = (r_q.state == PW_DUMMY) && q_last;
    assign redirect_addr = VEC_ADDR;
endmodule

// File: rtl/sleep_wake_ctl_chk.sv
module sleep_wake_ctl_chk #(
    parameter int                N_SRC    = 8,
    parameter int                ADDR_W   = 13,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 13'h004,
    parameter int                OST_LEN  = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  int_en,
    input logic [N_SRC-1:0]  int_flag,
    input logic [1:0]        osc_mode,
    input logic              core_halt,
    input logic              wdt_clr,
    input logic              pd_bit,
    input logic              ost_busy,
    input logic              redirect_vld,
    input logic [ADDR_W-1:0] redirect_addr
);
    localparam int RW = $clog2(OST_LEN + 1) + 1;

    logic          wake_c;
    logic          busy_prev_q;
    logic [RW-1:0] run_q;

    assign wake_c = |(int_en & int_flag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_prev_q <= 1'b0;
            run_q       <= '0;
        end else begin
            busy_prev_q <= ost_busy;
            if (ost_busy)
                run_q <= busy_prev_q ? run_q + 1'b1 : RW'(1);
        end
    end

    AST_HALT_PD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt |-> !pd_bit); // R4
    AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && !ost_busy && wake_c) |=> (ost_busy || !core_halt)); // R2
    AST_OST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ost_busy |-> core_halt); // R5
    AST_OST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ost_busy && busy_prev_q) |-> (run_q == RW'(OST_LEN))); // R5
    AST_RC_NO_OST: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && !ost_busy && osc_mode == 2'b11) |=> !ost_busy); // R6
    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> (redirect_addr == VEC_ADDR && !core_halt)); // R7
    AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_clr); // R9
    AST_HALTED_NO_WDT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && $past(core_halt)) |-> !wdt_clr); // R11
endmodule

bind sleep_wake_ctl sleep_wake_ctl_chk #(
    .N_SRC    (N_SRC),
    .ADDR_W   (ADDR_W),
    .VEC_ADDR (VEC_ADDR),
    .OST_LEN  (OST_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .int_en        (int_en),
    .int_flag      (int_flag),
    .osc_mode      (osc_mode),
    .core_halt     (core_halt),
    .wdt_clr       (wdt_clr),
    .pd_bit        (pd_bit),
    .ost_busy      (ost_busy),
    .redirect_vld  (redirect_vld),
    .redirect_addr (redirect_addr)
);

// File: tb/sleep_wake_ctl_tb_top.sv
`timescale 1ns/1ps
module sleep_wake_ctl_tb_top;
    localparam int N_SRC  = 8;
    localparam int ADDR_W = 13;
    localparam int K_WDT  = 1;
    localparam int K_RED  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep_stb = 1'b0, clrwdt_stb = 1'b0, wdt_tmo = 1'b0, gie = 1'b0;
    logic [N_SRC-1:0]  int_en = '0, int_flag = '0;
    logic [1:0]        osc_mode = 2'b10;
    logic              core_halt, wdt_clr, to_bit, pd_bit, ost_busy, redirect_vld;
    logic [ADDR_W-1:0] redirect_addr;

    typedef struct { int kind; longint cyc; } exp_t;
    exp_t   sb_q[$];
    int     compared = 0, mismatched = 0, redir_seen = 0;
    longint cyc = 0;
    bit     finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sleep_wake_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .clrwdt_stb(clrwdt_stb),
        .wdt_tmo(wdt_tmo), .gie(gie), .int_en(int_en), .int_flag(int_flag),
        .osc_mode(osc_mode), .core_halt(core_halt), .wdt_clr(wdt_clr),
        .to_bit(to_bit), .pd_bit(pd_bit), .ost_busy(ost_busy),
        .redirect_vld(redirect_vld), .redirect_addr(redirect_addr)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_evt(input int kind, input longint at);
        exp_t e;
        e.kind = kind;
        e.cyc  = at;
        sb_q.push_back(e);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        tick(4);
        sig = 1'b0;
    endtask

    // Monitor: pops one expected item per observed event.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (wdt_clr) begin
                compared++;
                if (sb_q.size() == 0 || sb_q[0].kind != K_WDT) begin
                    mismatched++;
                    $display("FAIL R3/R9/R11 unexpected wdt_clr: actual 1 expected 0");
                end
                if (sb_q.size() != 0) void'(sb_q.pop_front());
            end
            if (redirect_vld) begin
                redir_seen++;
                compared++;
                if (sb_q.size() == 0 || sb_q[0].kind != K_RED) begin
                    mismatched++;
                    $display("FAIL R7/R8 unexpected redirect: actual 1 expected 0");
                end else if (sb_q[0].cyc != cyc || redirect_addr != 13'h004) begin
                    mismatched++;
                    $display("FAIL R7 redirect cycle/addr: actual %0d/%0h expected %0d/4",
                             cyc, redirect_addr, sb_q[0].cyc);
                end
                if (sb_q.size() != 0) void'(sb_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 5);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int r0;
        longint c0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1", "core_halt", core_halt, 0);
        check("R1", "to_bit", to_bit, 1);
        check("R1", "pd_bit", pd_bit, 1);
        check("R1", "ost_busy", ost_busy, 0);
        check("R1", "redirect_vld", redirect_vld, 0);
        check("R1", "wdt_clr", wdt_clr, 0);

        // R10 time-out clears TO
        wdt_tmo = 1'b1; tick(1); wdt_tmo = 1'b0;
        check("R10", "to_bit after tmo", to_bit, 0);

        // R9 watchdog clear
        expect_evt(K_WDT, -1);
        pulse(clrwdt_stb);
        tick(1);
        check("R9", "to_bit", to_bit, 1);
        check("R9", "pd_bit", pd_bit, 1);

        // R3 sleep with a pending source is a no-op
        wdt_tmo = 1'b1; tick(1); wdt_tmo = 1'b0;
        int_en[0] = 1'b1; int_flag[0] = 1'b1;
        sleep_stb = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            check("R3", "core_halt during nop", core_halt, 0);
        end
        sleep_stb = 1'b0;
        tick(2);
        check("R3", "to_bit kept", to_bit, 0);
        check("R3", "pd_bit kept", pd_bit, 1);

        // R4 real sleep, HS mode, gie low
        int_flag = '0; osc_mode = 2'b10; gie = 1'b0;
        expect_evt(K_WDT, -1);
        pulse(sleep_stb);
        tick(2);
        check("R4", "core_halt", core_halt, 1);
        check("R4", "to_bit", to_bit, 1);
        check("R4", "pd_bit", pd_bit, 0);
        tick(20);
        check("R4", "still halted", core_halt, 1);

        // R11 strobes ignored while asleep
        pulse(clrwdt_stb);
        pulse(sleep_stb);
        tick(1);
        check("R11", "pd_bit stays 0", pd_bit, 0);
        check("R11", "still halted", core_halt, 1);

        // R2 flag without enable does not wake
        int_en = '0; int_en[0] = 1'b1; int_flag[1] = 1'b1;
        tick(10);
        check("R2", "masked flag no wake", core_halt, 1);
        check("R2", "masked flag no ost", ost_busy, 0);
        int_en[1] = 1'b1;
        tick(1);
        check("R5", "ost_busy rises", ost_busy, 1);
        tick(1023);
        check("R5", "ost_busy at 1024th clock", ost_busy, 1);
        check("R5", "halt during ost", core_halt, 1);
        tick(1);
        check("R5", "ost_busy ended", ost_busy, 0);
        check("R5", "halt released", core_halt, 0);
        r0 = redir_seen;
        tick(12);
        check("R8", "no redirect with gie low", redir_seen, r0);
        int_en = '0; int_flag = '0;

        // R6 RC mode, R7 vector with gie high
        osc_mode = 2'b11; gie = 1'b1; int_en[2] = 1'b1;
        expect_evt(K_WDT, -1);
        pulse(sleep_stb);
        tick(3);
        check("R6", "asleep before wake", core_halt, 1);
        int_flag[2] = 1'b1;
        tick(1);
        check("R6", "immediate release", core_halt, 0);
        check("R6", "no ost", ost_busy, 0);
        c0 = cyc;
        r0 = redir_seen;
        expect_evt(K_RED, c0 + 7);
        tick(12);
        check("R7", "one redirect", redir_seen, r0 + 1);
        int_flag = '0;

        // R5 and R7 in LP mode with gie high
        osc_mode = 2'b00;
        expect_evt(K_WDT, -1);
        pulse(sleep_stb);
        tick(3);
        int_flag[2] = 1'b1;
        tick(1);
        check("R5", "LP ost_busy", ost_busy, 1);
        tick(1024);
        check("R5", "LP released", core_halt, 0);
        c0 = cyc;
        r0 = redir_seen;
        expect_evt(K_RED, c0 + 7);
        tick(12);
        check("R7", "LP redirect", redir_seen, r0 + 1);

        tick(5);
        check("R4", "scoreboard drained", sb_q.size(), 0);
        finish_run();
    end
endmodule